// File: doc/BRIEF.md
# Privileged Interrupt Pending Selector

This block chooses the one local interrupt that a hart should service right now. It takes a pending mask, an enable mask and a delegation mask, each one bit per interrupt source. It also takes the hart's current privilege level and the global interrupt-enable bits for machine level and supervisor level. From these it produces a valid flag and the cause index of the chosen source. Both outputs are registered.

A source is a candidate when it is both pending and enabled. A candidate that is not delegated is then gated by the machine-level enable. A delegated candidate is gated by the supervisor-level enable instead. Each level enable is qualified by privilege: code running below a level can always be interrupted at that level. At that level itself, the matching global bit decides. Of the candidates that survive, the lowest-numbered one wins.

The trap-entry logic samples the outputs once per cycle. Producing the pending bits and any virtualised interrupt routing are handled elsewhere.

Top module: `irq_pend_select`

## Requirements
- R1: While reset is asserted, `take_valid_o` is 0 and `take_cause_o` is 0.
- R2: A source whose enable bit is 0 is never selected, even when it is pending.
- R3: Privilege is encoded as U=0, S=1 and M=3. The value 2 behaves exactly like U.
- R4: A non-delegated candidate (delegation bit 0) may be taken whenever privilege is U or S. In M it may be taken only when `mach_gie_i` is 1.
- R5: A delegated candidate (delegation bit 1) may always be taken in U. In S it may be taken only when `supv_gie_i` is 1. In M it is never taken.
- R6: When several candidates survive gating, `take_cause_o` is the index of the lowest-numbered one, for any index from 0 to 31.
- R7: When no candidate survives, `take_valid_o` is 0 and `take_cause_o` is 0.
- R8: The outputs show the result for the inputs sampled at the previous rising clock edge, which is a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 32 | Pending mask, one bit per source |
| enab_i | input | 32 | Per-source enable mask |
| deleg_i | input | 32 | Delegation mask; 1 routes the source to supervisor level |
| priv_i | input | 2 | Current privilege (0 U, 1 S, 2 as U, 3 M) |
| mach_gie_i | input | 1 | Machine-level global interrupt enable |
| supv_gie_i | input | 1 | Supervisor-level global interrupt enable |
| take_valid_o | output | 1 | An interrupt should be taken |
| take_cause_o | output | 5 | Index of the selected source |

## Verification
The selector is driven at each of the four privilege codes, with both global bits low and then high. Each setting is tried with delegated and non-delegated sources, which tells the machine-level gate apart from the supervisor-level gate. Patterns where a low-index source is gated off but a higher one survives show that gating happens before the priority pick. Further cases cover single-bit patterns at both ends of the mask, pending bits with their enables cleared, and many random masks. These separate the priority encoder from the masking logic.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    PRIV_USER = 2'd0,
    PRIV_SUPV = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_MACH = 2'd3
  } priv_e;

  // Machine-level gate: open below M, otherwise follows the global bit.
  function automatic logic mach_gate(input logic [1:0] priv, input logic gie);
    return (priv != PRIV_MACH) || gie;
  endfunction

  // Supervisor-level gate: open in U (and the reserved code), global bit in S, closed in M.
  function automatic logic supv_gate(input logic [1:0] priv, input logic gie);
    logic open_q;
    case (priv)
      PRIV_SUPV: open_q = gie;
      PRIV_MACH: open_q = 1'b0;
      default:   open_q = 1'b1;
    endcase
    return open_q;
  endfunction

endpackage

// File: rtl/irq_priv_gate.sv
module irq_priv_gate
  import irq_sel_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       mach_gie_i,
  input  logic       supv_gie_i,
  output logic       mach_open_o,
  output logic       supv_open_o
);

  always_comb begin
    mach_open_o = mach_gate(priv_i, mach_gie_i);
    supv_open_o = supv_gate(priv_i, supv_gie_i);
  end

endmodule

// File: rtl/irq_cand_filter.sv
module irq_cand_filter #(
  parameter int NUM_IRQ = 32
) (
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] enab_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic               mach_open_i,
  input  logic               supv_open_i,
  output logic [NUM_IRQ-1:0] cand_o,
  output logic [NUM_IRQ-1:0] surv_o
);

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
    logic lvl_open;
    assign cand_o[g] = pend_i[g] & enab_i[g];
    assign lvl_open  = deleg_i[g] ? supv_open_i : mach_open_i;
    assign surv_o[g] = cand_o[g] & lvl_open;
  end

endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0] surv_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);

  always_comb begin
    any_o = |surv_i;
    idx_o = '0;
    for (int i = NUM_IRQ - 1; i >= 0; i--) begin
      if (surv_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_pend_select.sv
module irq_pend_select #(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] enab_i,
  input  logic [NUM_IRQ-1:0] deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               mach_gie_i,
  input  logic               supv_gie_i,
  output logic               take_valid_o,
  output logic [IDX_W-1:0]   take_cause_o
);

  logic               mach_open_w;
  logic               supv_open_w;
  logic [NUM_IRQ-1:0] cand_w;
  logic [NUM_IRQ-1:0] surv_w;
  logic               any_w;
  logic [IDX_W-1:0]   idx_w;

  irq_priv_gate u_gate (
    .priv_i      (priv_i),
    .mach_gie_i  (mach_gie_i),
    .supv_gie_i  (supv_gie_i),
    .mach_open_o (mach_open_w),
    .supv_open_o (supv_open_w)
  );

  irq_cand_filter #(.NUM_IRQ(NUM_IRQ)) u_filt (
    .pend_i      (pend_i),
    .enab_i      (enab_i),
    .deleg_i     (deleg_i),
    .mach_open_i (mach_open_w),
    .supv_open_i (supv_open_w),
    .cand_o      (cand_w),
    .surv_o      (surv_w)
  );

  irq_lowest_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
    .surv_i (surv_w),
    .any_o  (any_w),
    .idx_o  (idx_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_valid_o <= 1'b0;
      take_cause_o <= '0;
    end else begin
      take_valid_o <= any_w;
      take_cause_o <= any_w ? idx_w : '0;
    end
  end

endmodule

// File: rtl/irq_pend_select_chk.sv
module irq_pend_select_chk #(
  parameter int NUM_IRQ = 32,
  localparam int IDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] enab_i,
  input logic [NUM_IRQ-1:0] deleg_i,
  input logic [1:0]         priv_i,
  input logic               mach_gie_i,
  input logic               supv_gie_i,
  input logic [NUM_IRQ-1:0] cand_w,
  input logic [NUM_IRQ-1:0] surv_w,
  input logic               take_valid_o,
  input logic [IDX_W-1:0]   take_cause_o
);

  logic [NUM_IRQ-1:0] below_mask;
  assign below_mask = (NUM_IRQ'(1) << take_cause_o) - NUM_IRQ'(1);

  always @(negedge clk) begin
    if (!rst_n) p_reset_idle_r1: assert (!take_valid_o && take_cause_o == '0);
  end

  p_cand_in_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid_o && $past(rst_n) |->
      ((($past(cand_w) & $past(enab_i)) >> take_cause_o) & NUM_IRQ'(1)) != '0);

  p_mach_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid_o && $past(rst_n) && $past(priv_i) == 2'd3 && !$past(mach_gie_i) |->
      (($past(deleg_i) >> take_cause_o) & NUM_IRQ'(1)) != '0);

  p_deleg_blocked_in_m_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid_o && $past(rst_n) && $past(priv_i) == 2'd3 |->
      (($past(deleg_i) >> take_cause_o) & NUM_IRQ'(1)) == '0);

  p_supv_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid_o && $past(rst_n) && $past(priv_i) == 2'd1 && !$past(supv_gie_i) |->
      (($past(deleg_i) >> take_cause_o) & NUM_IRQ'(1)) == '0);

  p_lowest_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid_o && $past(rst_n) |->
      ((($past(surv_w) >> take_cause_o) & NUM_IRQ'(1)) != '0) &&
      (($past(surv_w) & below_mask) == '0));

  p_idle_when_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(surv_w) == '0 |-> !take_valid_o && take_cause_o == '0);

  p_valid_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> take_valid_o == ($past(surv_w) != '0));

endmodule

bind irq_pend_select irq_pend_select_chk #(.NUM_IRQ(NUM_IRQ)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .enab_i       (enab_i),
  .deleg_i      (deleg_i),
  .priv_i       (priv_i),
  .mach_gie_i   (mach_gie_i),
  .supv_gie_i   (supv_gie_i),
  .cand_w       (cand_w),
  .surv_w       (surv_w),
  .take_valid_o (take_valid_o),
  .take_cause_o (take_cause_o)
);

// File: tb/irq_pend_select_tb_top.sv
module irq_pend_select_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pend = '0, enab = '0, deleg = '0;
  logic [1:0]  priv = 2'd0;
  logic        mgie = 1'b0, sgie = 1'b0;
  logic        valid;
  logic [4:0]  cause;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  typedef struct {
    logic       v;
    logic [4:0] c;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  irq_pend_select dut_i (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .enab_i(enab), .deleg_i(deleg),
    .priv_i(priv), .mach_gie_i(mgie), .supv_gie_i(sgie),
    .take_valid_o(valid), .take_cause_o(cause)
  );

  // Reference model written from the requirements: walk sources upward.
  function automatic exp_t model(input logic [31:0] p, e, d, input logic [1:0] pv,
                                 input logic mg, sg, input string tag);
    exp_t r;
    r.v = 0; r.c = 0; r.tag = tag;
    for (int i = 0; i < 32; i++) begin
      logic ok;
      if (!(p[i] && e[i])) continue;
      if (d[i]) ok = (pv == 2'd3) ? 1'b0 : (pv == 2'd1) ? sg : 1'b1;
      else      ok = (pv == 2'd3) ? mg : 1'b1;
      if (ok) begin r.v = 1; r.c = 5'(i); break; end
    end
    return r;
  endfunction

  task automatic drive(input logic [31:0] p, e, d, input logic [1:0] pv,
                       input logic mg, sg, input string tag);
    @(negedge clk);
    pend = p; enab = e; deleg = d; priv = pv; mgie = mg; sgie = sg;
    sb.push_back(model(p, e, d, pv, mg, sg, tag));
  endtask

  // Monitor: a quarter cycle after each rising edge, compare with the oldest expectation.
  always @(posedge clk) begin
    #5;
    if (rst_n && sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      n_cmp++;
      if (valid !== x.v || cause !== x.c) begin
        n_bad++;
        $display("FAIL %s: got valid=%0b cause=%0d, expected valid=%0b cause=%0d",
                 x.tag, valid, cause, x.v, x.c);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    finish_run();
  end

  initial begin
    pend = '1; enab = '1; mgie = 1;
    #35;
    n_cmp++;
    if (valid !== 1'b0 || cause !== 5'd0) begin
      n_bad++;
      $display("FAIL R1: got valid=%0b cause=%0d, expected valid=0 cause=0", valid, cause);
    end
    @(negedge clk); rst_n = 1;
    // R7: nothing pending
    drive('0, '1, '0, 2'd3, 1, 1, "R7 empty");
    // R2: pending without enable
    drive(32'h0000_00F0, 32'h0000_000F, '0, 2'd0, 1, 1, "R2 not enabled");
    drive(32'h0000_00F0, 32'h0000_0020, '0, 2'd0, 1, 1, "R2 only bit5 enabled");
    // R4: machine gate
    drive(32'h0000_0080, '1, '0, 2'd3, 1, 0, "R4 M with gie");
    drive(32'h0000_0080, '1, '0, 2'd3, 0, 0, "R4 M without gie");
    drive(32'h0000_0080, '1, '0, 2'd1, 0, 0, "R4 S below M");
    // R5: supervisor gate
    drive(32'h0000_0200, '1, 32'h0000_0200, 2'd3, 1, 1, "R5 M never delegated");
    drive(32'h0000_0200, '1, 32'h0000_0200, 2'd1, 1, 0, "R5 S without sie");
    drive(32'h0000_0200, '1, 32'h0000_0200, 2'd1, 0, 1, "R5 S with sie");
    drive(32'h0000_0200, '1, 32'h0000_0200, 2'd0, 0, 0, "R5 U always");
    // R3: code 2 behaves as U
    drive(32'h0000_0202, '1, 32'h0000_0200, 2'd2, 0, 0, "R3 reserved as U");
    drive(32'h0000_0200, '1, 32'h0000_0200, 2'd2, 0, 0, "R3 reserved deleg");
    // R6: priority and ends of the mask
    drive(32'hF000_0F10, '1, '0, 2'd0, 0, 0, "R6 lowest of many");
    drive(32'h8000_0000, '1, '0, 2'd0, 0, 0, "R6 bit31");
    drive(32'h0000_0001, '1, '0, 2'd0, 0, 0, "R6 bit0");
    drive(32'h0100_0008, '1, 32'h0000_0008, 2'd3, 1, 1, "R5 R6 gated low loses");
    drive(32'h0100_0008, '1, 32'h0100_0000, 2'd1, 1, 0, "R6 S mixed");
    // R8: back-to-back changes, each seen one cycle later
    drive(32'h0000_0004, '1, '0, 2'd0, 0, 0, "R8 step a");
    drive(32'h0000_0400, '1, '0, 2'd0, 0, 0, "R8 step b");
    drive('0, '1, '0, 2'd0, 0, 0, "R8 step c");
    // R6: random masks across all privileges
    for (int k = 0; k < 300; k++) begin
      drive($urandom & $urandom, $urandom | $urandom, $urandom, 2'($urandom),
            1'($urandom), 1'($urandom), "R6 random");
    end
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule